// File: doc/BRIEF.md
# Multiplexed ADC Acquisition Sequencer

This block paces the sampling of a protection front end. A divider on the system clock produces one sampling tick per millisecond. On each tick the block raises a single hold command that freezes all analog inputs at the same instant. It then walks an eight-input analog multiplexer through the six inputs that carry signals, in a fixed order: three phase voltages followed by three phase currents. For each input it starts one conversion on an external 12-bit converter, waits for the converter to finish, and stores the two's-complement result.

The converter is controlled through a start pulse. It reports back through a busy level and a 12-bit data bus. If busy does not clear within a bounded window, the block gives up on that input, stores zero for it, marks the frame as bad and sets an error flag that stays set until reset. After the sixth input the hold is released. One cycle later the complete frame of six samples is presented, together with a one-cycle valid strobe and a per-frame good flag.

Top module: `adc_acq_seq`

## Requirements
- R1: Hold rises exactly once per sampling period, and successive rising edges are TICK_DIV clock cycles apart (50000 at 50 MHz gives 1 kHz).
- R2: A start pulse occurs only while hold is high. Hold stays high from the cycle after the tick until the last conversion has finished, and then drops.
- R3: Each conversion start is a single-cycle pulse, and the multiplexer select does not change in the cycle after it. The first start comes ACQ_CYC+SETTLE_CYC cycles after hold rises. Every later start comes SETTLE_CYC cycles after the select changes.
- R4: The select steps through inputs 0,1,2,3,4,5 once per frame, in that order. Inputs 0–2 are the voltages and 3–5 are the currents. Inputs 6 and 7 are never selected.
- R5: A result is taken from adc_data in the first cycle after the start cycle in which busy is low. frame_data bits [12k+11:12k] hold the result of input k. frame_valid is high for exactly one cycle, one cycle after hold falls.
- R6: If busy is still high TIMEOUT_CYC cycles after the start cycle, that input is abandoned and its slot reads zero. The frame is then delivered with frame_ok low, and conv_err is set and stays set until reset.
- R7: A conversion whose busy is seen low exactly TIMEOUT_CYC cycles after the start cycle is accepted as valid. A frame with no timeout is delivered with frame_ok high, even when conv_err is already set.
- R8: While and just after rst is asserted, hold, adc_start, frame_valid, frame_ok and conv_err are all 0, and mux_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_busy | input | 1 | Converter busy level |
| adc_data | input | 12 | Converter result, two's complement |
| hold | output | 1 | Common sample-and-hold command |
| mux_sel | output | 3 | Analog multiplexer input select |
| adc_start | output | 1 | One-cycle conversion start pulse |
| frame_valid | output | 1 | One-cycle strobe: a new frame is on frame_data |
| frame_ok | output | 1 | Frame completed with no conversion timeout |
| frame_data | output | 72 | Six packed samples, input k at bits [12k+11:12k] |
| conv_err | output | 1 | Sticky conversion timeout flag |

## Verification
Every timing result is measured as a distance in clock cycles from an earlier port event:
- Successive hold rises must be TICK_DIV cycles apart.
- The first start must come ACQ_CYC+SETTLE_CYC cycles after hold rises.
- Each later start must come SETTLE_CYC cycles after the select changes.
- The valid strobe must come exactly one cycle after hold falls.

A behavioural converter stub asserts busy for a chosen number of cycles per input. With it, the accept boundary (busy cleared exactly TIMEOUT_CYC cycles after start) and a stuck conversion both land in known cycles. The bench samples every output on the falling edge and counts cycles on the rising edge, so each distance it compares is an exact integer.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    localparam int SMP_W_DEF  = 12;
    localparam int MUX_W_DEF  = 3;
    localparam int N_SLOT_DEF = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_SETTLE,
        ST_START,
        ST_CONV,
        ST_DONE
    } seq_st_t;

    // Slot k (0..2 voltages, 3..5 currents) is wired to multiplexer input k.
    function automatic int slot_to_mux(input int slot);
        return slot;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/acq_tick_gen.sv
module acq_tick_gen #(
    parameter int TICK_DIV = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
    import acq_seq_pkg::*;
#(
    parameter int N_SLOT      = N_SLOT_DEF,
    parameter int MUX_W       = MUX_W_DEF,
    parameter int ACQ_CYC     = 100,
    parameter int SETTLE_CYC  = 50,
    parameter int TIMEOUT_CYC = 1250,
    localparam int SLOT_W     = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              adc_busy,
    output logic              hold,
    output logic [MUX_W-1:0]  mux_sel,
    output logic              adc_start,
    output logic              cap_en,
    output logic              cap_zero,
    output logic [SLOT_W-1:0] cap_slot,
    output logic              commit,
    output logic              commit_ok,
    output logic              conv_err
);
    localparam int WCW = $clog2(max3(ACQ_CYC, SETTLE_CYC, TIMEOUT_CYC) + 1);
    localparam logic [WCW-1:0]    ACQ_LAST  = WCW'(ACQ_CYC - 1);
    localparam logic [WCW-1:0]    SET_LAST  = WCW'(SETTLE_CYC - 1);
    localparam logic [WCW-1:0]    TMO_LAST  = WCW'(TIMEOUT_CYC - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_SLOT - 1);

    seq_st_t           state;
    logic [WCW-1:0]    wcnt;
    logic [SLOT_W-1:0] slot;
    logic              bad;
    logic              err_q;
    logic              conv_ok;
    logic              conv_tmo;

    // Busy is not trusted in the first wait cycle; the converter needs an edge to raise it.
    assign conv_ok  = (state == ST_CONV) && (wcnt != '0) && !adc_busy;
    assign conv_tmo = (state == ST_CONV) && !conv_ok && (wcnt == TMO_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            wcnt  <= '0;
            slot  <= '0;
            bad   <= 1'b0;
            err_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (tick) begin
                        state <= ST_ACQ;
                        wcnt  <= '0;
                        slot  <= '0;
                        bad   <= 1'b0;
                    end
                end
                ST_ACQ: begin
                    if (wcnt == ACQ_LAST) begin
                        state <= ST_SETTLE;
                        wcnt  <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (wcnt == SET_LAST) begin
                        state <= ST_START;
                        wcnt  <= '0;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_START: begin
                    state <= ST_CONV;
                    wcnt  <= '0;
                end
                ST_CONV: begin
                    if (conv_ok || conv_tmo) begin
                        wcnt <= '0;
                        if (conv_tmo) begin
                            bad   <= 1'b1;
                            err_q <= 1'b1;
                        end
                        if (slot == SLOT_LAST) begin
                            state <= ST_DONE;
                        end else begin
                            slot  <= slot + 1'b1;
                            state <= ST_SETTLE;
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                    slot  <= '0;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign hold      = (state == ST_ACQ) || (state == ST_SETTLE) ||
                       (state == ST_START) || (state == ST_CONV);
    assign mux_sel   = MUX_W'(slot_to_mux(int'(slot)));
    assign adc_start = (state == ST_START);
    assign cap_en    = conv_ok || conv_tmo;
    assign cap_zero  = conv_tmo;
    assign cap_slot  = slot;
    assign commit    = (state == ST_DONE);
    assign commit_ok = !bad;
    assign conv_err  = err_q;
endmodule

// File: rtl/acq_sample_store.sv
module acq_sample_store #(
    parameter int N_SLOT  = 6,
    parameter int SMP_W   = 12,
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cap_en,
    input  logic                    cap_zero,
    input  logic [SLOT_W-1:0]       cap_slot,
    input  logic [SMP_W-1:0]        cap_data,
    input  logic                    commit,
    input  logic                    commit_ok,
    output logic                    frame_valid,
    output logic                    frame_ok,
    output logic [N_SLOT*SMP_W-1:0] frame_data
);
    logic [SMP_W-1:0] cur [N_SLOT];

    for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                cur[k] <= '0;
            end else if (cap_en && (cap_slot == SLOT_W'(k))) begin
                cur[k] <= cap_zero ? '0 : cap_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                frame_data[k*SMP_W +: SMP_W] <= '0;
            end else if (commit) begin
                frame_data[k*SMP_W +: SMP_W] <= cur[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_valid <= 1'b0;
            frame_ok    <= 1'b0;
        end else begin
            frame_valid <= commit;
            if (commit) begin
                frame_ok <= commit_ok;
            end
        end
    end
endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
    import acq_seq_pkg::*;
#(
    parameter int TICK_DIV    = 50000,
    parameter int ACQ_CYC     = 100,
    parameter int SETTLE_CYC  = 50,
    parameter int TIMEOUT_CYC = 1250,
    parameter int N_SLOT      = N_SLOT_DEF,
    parameter int MUX_W       = MUX_W_DEF,
    parameter int SMP_W       = SMP_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adc_busy,
    input  logic [SMP_W-1:0]        adc_data,
    output logic                    hold,
    output logic [MUX_W-1:0]        mux_sel,
    output logic                    adc_start,
    output logic                    frame_valid,
    output logic                    frame_ok,
    output logic [N_SLOT*SMP_W-1:0] frame_data,
    output logic                    conv_err
);
    localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

    logic              tick;
    logic              cap_en;
    logic              cap_zero;
    logic [SLOT_W-1:0] cap_slot;
    logic              commit;
    logic              commit_ok;

    acq_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    acq_seq_ctrl #(
        .N_SLOT      (N_SLOT),
        .MUX_W       (MUX_W),
        .ACQ_CYC     (ACQ_CYC),
        .SETTLE_CYC  (SETTLE_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .adc_busy  (adc_busy),
        .hold      (hold),
        .mux_sel   (mux_sel),
        .adc_start (adc_start),
        .cap_en    (cap_en),
        .cap_zero  (cap_zero),
        .cap_slot  (cap_slot),
        .commit    (commit),
        .commit_ok (commit_ok),
        .conv_err  (conv_err)
    );

    acq_sample_store #(
        .N_SLOT (N_SLOT),
        .SMP_W  (SMP_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .cap_en      (cap_en),
        .cap_zero    (cap_zero),
        .cap_slot    (cap_slot),
        .cap_data    (adc_data),
        .commit      (commit),
        .commit_ok   (commit_ok),
        .frame_valid (frame_valid),
        .frame_ok    (frame_ok),
        .frame_data  (frame_data)
    );
endmodule

// File: rtl/adc_acq_seq_chk.sv
module adc_acq_seq_chk #(
    parameter int N_SLOT = 6,
    parameter int MUX_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             hold,
    input logic [MUX_W-1:0] mux_sel,
    input logic             adc_start,
    input logic             frame_valid,
    input logic             frame_ok,
    input logic             conv_err
);
    a_r2_start_in_hold: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> hold);

    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    a_r3_mux_held: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> $stable(mux_sel));

    a_r4_no_spare: assert property (@(posedge clk) disable iff (rst)
        hold |-> (int'(mux_sel) < N_SLOT));

    a_r5_valid_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(hold) |=> frame_valid);

    a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        conv_err |=> conv_err);

    a_r6_bad_frame_flags: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !frame_ok) |-> conv_err);
endmodule

bind adc_acq_seq adc_acq_seq_chk #(.N_SLOT(N_SLOT), .MUX_W(MUX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hold        (hold),
    .mux_sel     (mux_sel),
    .adc_start   (adc_start),
    .frame_valid (frame_valid),
    .frame_ok    (frame_ok),
    .conv_err    (conv_err)
);

// File: tb/tb_adc_acq_seq.sv
`timescale 1ns/1ps
module tb_adc_acq_seq;
    localparam int TICK_DIV = 1500;
    localparam int ACQ      = 20;
    localparam int SETTLE   = 10;
    localparam int TMO      = 100;
    localparam int NS       = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_busy;
    logic [11:0] adc_data;
    logic        hold;
    logic [2:0]  mux_sel;
    logic        adc_start;
    logic        frame_valid;
    logic        frame_ok;
    logic [71:0] frame_data;
    logic        conv_err;

    always #2.5 clk = ~clk;

    adc_acq_seq #(
        .TICK_DIV(TICK_DIV), .ACQ_CYC(ACQ), .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TMO)
    ) dut (
        .clk(clk), .rst(rst), .adc_busy(adc_busy), .adc_data(adc_data),
        .hold(hold), .mux_sel(mux_sel), .adc_start(adc_start),
        .frame_valid(frame_valid), .frame_ok(frame_ok),
        .frame_data(frame_data), .conv_err(conv_err)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter stub
    logic [11:0] ch_val   [8];
    int          conv_len [8];
    logic        stuck    [8];
    int          bcnt;
    logic        stuck_cur;

    always @(posedge clk) begin
        if (rst) begin
            adc_busy  <= 1'b0;
            adc_data  <= '0;
            bcnt      <= 0;
            stuck_cur <= 1'b0;
        end else if (adc_start) begin
            adc_busy  <= 1'b1;
            bcnt      <= conv_len[mux_sel];
            adc_data  <= ch_val[mux_sel];
            stuck_cur <= stuck[mux_sel];
        end else if (adc_busy && !stuck_cur) begin
            if (bcnt <= 1) adc_busy <= 1'b0;
            else           bcnt <= bcnt - 1;
        end
    end

    // Port monitor, sampled on falling edges
    int   cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic prev_hold = 1'b0;
    logic [2:0] prev_mux = '0;
    int   rise_cyc = -1;
    int   fall_cyc = -1;
    int   mux_chg  = 0;
    int   ord_n    = 0;
    int   ord [8];

    always @(negedge clk) begin
        if (!rst) begin
            if (mux_sel != prev_mux) mux_chg = cyc;
            if (hold && !prev_hold) begin
                if (rise_cyc >= 0) chk("R1 hold period", cyc - rise_cyc, TICK_DIV);
                rise_cyc = cyc;
                ord_n = 0;
            end
            if (!hold && prev_hold) fall_cyc = cyc;
            if (adc_start) begin
                if (ord_n == 0) chk("R3 first start delay", cyc - rise_cyc, ACQ + SETTLE);
                else            chk("R3 settle before start", cyc - mux_chg, SETTLE);
                if (ord_n < 8) ord[ord_n] = int'(mux_sel);
                ord_n++;
            end
            if (frame_valid) chk("R5 valid after hold fall", cyc - fall_cyc, 1);
        end
        prev_hold = hold;
        prev_mux  = mux_sel;
    end

    task automatic wait_frame(input string tag, input logic exp_ok, input logic exp_err);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!frame_valid && guard < 4000);
        chk({tag, " R5 frame arrived"}, frame_valid, 1'b1);
        chk({tag, " R4 six selects"}, ord_n, NS);
        for (int k = 0; k < NS; k++) begin
            chk({tag, " R4 select order"}, ord[k], k);
            chk({tag, " R5 slot data"}, frame_data[k*12 +: 12],
                stuck[k] ? 12'h000 : ch_val[k]);
        end
        chk({tag, " R6/R7 frame_ok"}, frame_ok, exp_ok);
        chk({tag, " R6 conv_err"}, conv_err, exp_err);
    endtask

    task automatic sc_reset_state();
        chk("R8 hold", hold, 0);
        chk("R8 start", adc_start, 0);
        chk("R8 valid", frame_valid, 0);
        chk("R8 ok", frame_ok, 0);
        chk("R8 err", conv_err, 0);
        chk("R8 mux", mux_sel, 0);
    endtask

    task automatic sc_normal();
        wait_frame("normal-A", 1'b1, 1'b0);
        ch_val[0] = 12'h800; ch_val[1] = 12'h7FF; ch_val[2] = 12'hFFE;
        ch_val[3] = 12'h000; ch_val[4] = 12'h3A1; ch_val[5] = 12'hC5F;
        for (int k = 0; k < 8; k++) conv_len[k] = 5 + 7 * k;
        wait_frame("normal-B", 1'b1, 1'b0);
    endtask

    task automatic sc_boundary();
        conv_len[3] = TMO - 1;   // busy seen low exactly TMO cycles after start
        conv_len[0] = 1;
        wait_frame("R7 accept at limit", 1'b1, 1'b0);
        conv_len[3] = 40;
        conv_len[0] = 40;
    endtask

    task automatic sc_timeout();
        stuck[4] = 1'b1;
        wait_frame("R6 stuck input", 1'b0, 1'b1);
        stuck[4] = 1'b0;
        ch_val[4] = 12'h456;
        wait_frame("R6 err stays, R7 ok after", 1'b1, 1'b1);
    endtask

    task automatic sc_reset_clears();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        sc_reset_state();
        rst = 1'b0;
        rise_cyc = -1;
        wait_frame("R8 after reset", 1'b1, 1'b0);
    endtask

    initial begin
        ch_val[0] = 12'h7FF; ch_val[1] = 12'h800; ch_val[2] = 12'h001;
        ch_val[3] = 12'hFFF; ch_val[4] = 12'h123; ch_val[5] = 12'hA5C;
        ch_val[6] = 12'h3C3; ch_val[7] = 12'h5A5;
        for (int k = 0; k < 8; k++) begin
            conv_len[k] = 40;
            stuck[k]    = 1'b0;
        end
        repeat (4) @(negedge clk);
        sc_reset_state();
        rst = 1'b0;
        @(negedge clk);
        sc_reset_state();
        sc_normal();
        sc_boundary();
        sc_timeout();
        sc_reset_clears();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule